// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the last stage of a synchronous SRAM's read path. It takes the word that the array produces for a registered read command and places it on the data bus. A static mode input chooses when that happens. In flow-through mode the array word passes straight to the bus in the same cycle as the registered command. In pipelined mode the word is first captured in an output register on the rising clock edge, so it appears one cycle later and stays steady for the whole cycle.

The block also decides when the output drivers are on. High impedance is modelled as a separate drive-enable output. A deselect turns the drivers off one stage sooner than a read turns them on: the drivers do not hold stale data for an extra cycle after the final beat of a burst. A registered write cycle never turns the drivers on, so the bus stays free for write data. An active-low output enable gates the drivers without waiting for a clock edge.

The registered command uses this 2-bit code: 0 = idle (deselect), 1 = read, 2 = write, 3 = treated as idle.

Top module: `sram_rd_outstage`

## Requirements
- R1: With `pipe_mode` = 0, in any cycle where `op` = 1 (read) and `oe_n` = 0, `dout_en` is 1 and `dout` equals `arr_data` of that same cycle.
- R2: With `pipe_mode` = 1, in a cycle that follows a cycle with `op` = 1, when the current `op` is not 2 and `oe_n` = 0, `dout_en` is 1 and `dout` equals the `arr_data` value present at the rising edge that ended the read cycle.
- R3: A run of four back-to-back reads gives one beat per cycle in both modes. The first beat appears in the read's own cycle in flow-through mode and one cycle later in pipelined mode.
- R4: After the last read of a burst, when `op` = 0 is registered, `dout_en` goes low in that same cycle in flow-through mode, and in the next cycle in pipelined mode, with no extra hold cycle.
- R5: In any cycle where `op` = 2 (write), `dout_en` is 0 in both modes, even right after a pipelined read.
- R6: While `oe_n` = 1, `dout_en` is 0. A change of `oe_n` takes effect on `dout_en` without a clock edge.
- R7: After synchronous reset (`rst_n` low across a rising edge) with `op` = 0, `dout_en` is 0 in both modes.
- R8: Code `op` = 3 behaves as idle: it enables no drive in its own cycle and starts no pipelined beat in the next cycle.
- R9: With `pipe_mode` = 1, a change of `arr_data` during a driven cycle leaves `dout` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pipe_mode | input | 1 | Static mode: 1 = pipelined, 0 = flow-through |
| op | input | 2 | Registered command: 0 idle, 1 read, 2 write, 3 idle |
| arr_data | input | DW (36) | Word read from the array for the registered command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DW (36) | Data presented to the bus drivers |
| dout_en | output | 1 | Drive enable; 0 means the bus is high impedance |

## Verification
The bench runs directed four-beat bursts in each mode. These separate the one-cycle latency offset between the two paths and show whether the final beat survives the deselect that follows it. Read-then-write and read-then-code-3 pairs show whether a write blocks the drivers and whether the unused code is mistaken for a read. Mid-cycle toggles of the output enable and of the array word separate the asynchronous gate from the registered data path. Long seeded random runs in each mode mix all four codes and the enable, so that ordering faults between the drive stage and the data register show up.

// File: rtl/sram_outstg_pkg.sv
// Shared command encoding for the SRAM read output stage.
package sram_outstg_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_NONE  = 2'd3
    } op_e;
endpackage

// File: rtl/sram_outstg_capture.sv
// Output data path: the register that captures the array word on reads,
// and the mode mux that chooses between register and bypass.
// Assumes pipe_mode is static while reads are in flight.
module sram_outstg_capture
    import sram_outstg_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic [1:0]    op,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] data_q;

    // Capture the array word at the end of every read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (op == OP_READ)
            data_q <= arr_data;
    end

    // Select the registered word or the bypass path.
    always_comb begin
        dout = pipe_mode ? data_q : arr_data;
    end
endmodule

// File: rtl/sram_outstg_drive.sv
// Drive-enable control. A read drives the bus in its own cycle
// (flow-through) or the next cycle (pipelined). An idle cycle ends the
// drive with no extra hold stage. Write cycles never drive. oe_n gates
// the result combinationally. Assumes pipe_mode is static.
module sram_outstg_drive
    import sram_outstg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pipe_mode,
    input  logic [1:0] op,
    input  logic       oe_n,
    output logic       drv_en
);
    logic rd_stage_q;
    logic sync_en;

    // Remember whether the previous cycle carried a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_stage_q <= 1'b0;
        else
            rd_stage_q <= (op == OP_READ);
    end

    // Clocked part of the enable, chosen by mode.
    always_comb begin
        if (pipe_mode)
            sync_en = rd_stage_q && (op != OP_WRITE);
        else
            sync_en = (op == OP_READ);
    end

    // Asynchronous output-enable gate.
    always_comb begin
        drv_en = sync_en && !oe_n;
    end
endmodule

// File: rtl/sram_rd_outstage.sv
// Top of the SRAM read output stage: data path plus drive control.
// Assumes op comes from the input register stage and arr_data is valid
// in the same cycle as a registered read.
module sram_rd_outstage
    import sram_outstg_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic [1:0]    op,
    input  logic [DW-1:0] arr_data,
    input  logic          oe_n,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    sram_outstg_capture #(.DW(DW)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .op        (op),
        .arr_data  (arr_data),
        .dout      (dout)
    );

    sram_outstg_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .op        (op),
        .oe_n      (oe_n),
        .drv_en    (dout_en)
    );
endmodule

// File: rtl/sram_rd_outstage_chk.sv
// Property checker for the read output stage, bound to the top module.
module sram_rd_outstage_chk
    import sram_outstg_pkg::*;
#(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_mode,
    input logic [1:0]    op,
    input logic [DW-1:0] arr_data,
    input logic          oe_n,
    input logic [DW-1:0] dout,
    input logic          dout_en
);
    AST_FLOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && op == OP_READ && !oe_n) |-> (dout_en && dout == arr_data)); // R1

    AST_PIPE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && $past(rst_n) && $past(op) == OP_READ
         && op != OP_WRITE && !oe_n) |-> (dout_en && dout == $past(arr_data))); // R2

    AST_PIPE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(rst_n) && $past(op) != OP_READ) |-> !dout_en); // R4

    AST_FLOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && op != OP_READ) |-> !dout_en); // R8

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WRITE) |-> !dout_en); // R5

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en); // R6

    AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && $past(rst_n) && $past(op) != OP_READ)
        |-> $stable(dout)); // R9
endmodule

bind sram_rd_outstage sram_rd_outstage_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .op        (op),
    .arr_data  (arr_data),
    .oe_n      (oe_n),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/sram_rd_outstage_tb.sv
module sram_rd_outstage_tb;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b0;
    logic [1:0]    op = 2'd0;
    logic [DW-1:0] arr_data = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Bench model of the pipeline stage.
    logic          prev_rd = 1'b0;
    logic [DW-1:0] prev_dat = '0;

    always #10 clk = ~clk;

    sram_rd_outstage #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .op(op),
        .arr_data(arr_data), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_en(logic m, logic [1:0] o, logic pr, logic oe);
        if (oe) return 1'b0;
        if (m) return pr && (o != 2'd2);
        return o == 2'd1;
    endfunction

    function automatic logic [DW-1:0] exp_dat(logic m, logic [DW-1:0] d, logic [DW-1:0] pd);
        return m ? pd : d;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return DW'({$urandom(), $urandom()});
    endfunction

    // One clock cycle: drive after the edge, check in mid-cycle.
    task automatic cyc(string tag, logic m, logic [1:0] o, logic [DW-1:0] d, logic oe);
        logic e;
        @(posedge clk);
        #2;
        pipe_mode = m; op = o; arr_data = d; oe_n = oe;
        #6;
        e = exp_en(m, o, prev_rd, oe);
        chk({tag, " en"}, DW'(dout_en), DW'(e));
        if (e) chk({tag, " data"}, dout, exp_dat(m, d, prev_dat));
        prev_rd = (o == 2'd1);
        if (o == 2'd1) prev_dat = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R7: reset state
        repeat (3) @(posedge clk);
        pipe_mode = 1'b1; op = 2'd0; oe_n = 1'b0;
        #5 chk("R7 reset pipe en", DW'(dout_en), '0);
        @(posedge clk); #2; rst_n = 1'b1;
        #6 chk("R7 after reset pipe en", DW'(dout_en), '0);
        pipe_mode = 1'b0;
        #1 chk("R7 after reset flow en", DW'(dout_en), '0);

        // R1 R3 R4: flow-through burst then idle
        for (int i = 0; i < 4; i++) cyc("R1 R3 flow burst", 1'b0, 2'd1, DW'(36'h1_0000_0000 + i), 1'b0);
        cyc("R4 flow desel", 1'b0, 2'd0, rnd_word(), 1'b0);
        cyc("R4 flow idle", 1'b0, 2'd0, rnd_word(), 1'b0);

        // R2 R3 R4: pipelined burst then idle
        cyc("R3 pipe first cmd", 1'b1, 2'd1, 36'hA_AAAA_0000, 1'b0);
        for (int i = 1; i < 4; i++) cyc("R2 R3 pipe burst", 1'b1, 2'd1, DW'(36'hA_AAAA_0000 + i), 1'b0);
        cyc("R4 pipe last beat", 1'b1, 2'd0, rnd_word(), 1'b0);
        cyc("R4 pipe off", 1'b1, 2'd0, rnd_word(), 1'b0);

        // R5: write after read, both modes
        cyc("R5 pipe read", 1'b1, 2'd1, 36'h5_1234_5678, 1'b0);
        cyc("R5 pipe write", 1'b1, 2'd2, rnd_word(), 1'b0);
        cyc("R5 pipe after write", 1'b1, 2'd0, rnd_word(), 1'b0);
        cyc("R5 flow write", 1'b0, 2'd2, rnd_word(), 1'b0);
        cyc("R5 flow idle", 1'b0, 2'd0, rnd_word(), 1'b0);

        // R8: code 3 as idle
        cyc("R8 flow code3", 1'b0, 2'd3, rnd_word(), 1'b0);
        cyc("R8 pipe code3", 1'b1, 2'd3, rnd_word(), 1'b0);
        cyc("R8 pipe after code3", 1'b1, 2'd0, rnd_word(), 1'b0);

        // R6: asynchronous oe_n in flow-through mode
        cyc("R6 flow read", 1'b0, 2'd1, 36'h6_0000_0066, 1'b0);
        oe_n = 1'b1;
        #1 chk("R6 oe high no edge", DW'(dout_en), '0);
        oe_n = 1'b0;
        #1 chk("R6 oe low no edge", DW'(dout_en), DW'(1));
        cyc("R6 flow idle", 1'b0, 2'd0, rnd_word(), 1'b0);

        // R9: pipelined output steady against array changes mid-cycle
        cyc("R9 pipe read", 1'b1, 2'd1, 36'h9_0000_0009, 1'b0);
        cyc("R9 pipe beat", 1'b1, 2'd1, 36'h9_0000_0010, 1'b0);
        arr_data = 36'h9_FFFF_FFFF;
        #1 chk("R9 dout held", dout, 36'h9_0000_0009);
        prev_dat = 36'h9_FFFF_FFFF;
        cyc("R9 next beat", 1'b1, 2'd0, rnd_word(), 1'b0);
        cyc("R9 idle", 1'b1, 2'd0, rnd_word(), 1'b0);

        // Random runs per mode (R1 R2 R4 R5 R6 R8)
        for (int m = 0; m < 2; m++) begin
            cyc("R4 mode switch idle", m[0], 2'd0, rnd_word(), 1'b0);
            for (int n = 0; n < 600; n++) begin
                logic [1:0] o;
                logic oe;
                o  = 2'($urandom_range(0, 3));
                oe = ($urandom_range(0, 3) == 0);
                cyc(m[0] ? "R2 random pipe" : "R1 random flow", m[0], o, rnd_word(), oe);
            end
        end
        cyc("final idle", 1'b0, 2'd0, '0, 1'b0);
        finish_run();
    end
endmodule